// File: doc/BRIEF.md
# Double-Buffered Crosspoint Configuration Bank

This block stores the connection map of a 34-output by 34-input crosspoint and applies it to 34 single-bit data lanes. Every output owns two 6-bit registers: a staging register that the host writes, and an active register that steers the output's input selector. A single update strobe moves all staged words into the active rank in one clock, so a whole new map takes effect at one instant. A transparent mode lets a write land in both ranks in the same edge, so the switch reacts at once.

The host port is a synchronous parallel interface: a 7-bit address, a 6-bit write bus, chip select, write enable, read enable, update and transparent controls, and an active-high reset. Addresses 0 to 33 reach the connection words. Addresses 64 to 97 reach a second double-buffered bank that holds a per-output drive-strength code, which is presented as plain bits. Readback always returns the active rank of the addressed row, never the staged one.

Top module: `xpt_cfg_bank`

## Requirements
- R1: While rst is high at a clock edge, every connection word (staged and active) becomes 63 and every drive code becomes 0, so after reset all lane outputs are 0, a read of address 0 to 33 returns 63 and a read of address 64 to 97 returns 0.
- R2: With cs and we high at an edge and xpar low, data bits 5:0 go into the staging word of the addressed row only; the lane outputs and readback of that row keep their old values until an update.
- R3: With upd high at an edge, every staged word of both banks is copied into its active word at that edge, and the lane outputs follow from the next cycle.
- R4: An active connection code c from 0 to 33 makes lane_out[o] equal lane_in[c] combinationally; any code from 34 to 63 drives lane_out[o] to 0.
- R5: When cs and re are both high, rd_data shows the active word of the addressed row (address 0 to 33 for the connection bank, 64 to 97 for the drive bank, row = address - 64); otherwise, and for any other address, rd_data is 0.
- R6: Writes to addresses 64 to 97 program the drive bank with the same staging and update rules; drv_code bits [6*r+5:6*r] carry the active drive code of output r.
- R7: A write to address 34 to 63 or 98 to 127 changes no register in either bank.
- R8: With xpar high, a valid write updates both the staging and the active word of the addressed row at the same edge.
- R9: If upd and a non-transparent write to the same row coincide, the active word receives the old staged value and the new value stays staged for the next update.
- R10: With cs low, we has no effect on any register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hp_addr | input | 7 | Host register address |
| hp_wdata | input | 6 | Host write data |
| hp_cs | input | 1 | Chip select |
| hp_we | input | 1 | Write enable |
| hp_re | input | 1 | Read enable, gates rd_data |
| hp_upd | input | 1 | Global update strobe |
| hp_xpar | input | 1 | Transparent write-and-apply mode |
| lane_in | input | 34 | Input data lanes |
| lane_out | output | 34 | Output data lanes |
| rd_data | output | 6 | Readback of the active word |
| drv_code | output | 204 | Active drive codes, 6 bits per output |

## Verification
A corrupted active word shows on lane_out in the very cycle it is wrong, because the selector is combinational, and it shows on rd_data whenever that row is read. A corrupted staging word stays invisible until the next update, after which it appears on lane_out, drv_code and readback one cycle later; the bench therefore pairs every staging write with a later update and readback. Collisions between update and write, transparent writes and writes to unmapped addresses are each followed by a readback of the touched row.

// File: rtl/xpt_cfg_pkg.sv
package xpt_cfg_pkg;

    localparam int XPT_PORTS    = 34;
    localparam int XPT_CODE_W   = 6;
    localparam int XPT_ADDR_W   = 7;
    localparam int XPT_DRV_BASE = 64;

    typedef enum logic [1:0] {
        BANK_NONE = 2'd0,
        BANK_CONN = 2'd1,
        BANK_DRV  = 2'd2
    } bank_e;

    // Code values below the port count select an input; the rest disconnect.
    function automatic logic code_connects(input int code, input int nport);
        return code < nport;
    endfunction

endpackage

// File: rtl/xpt_host_decode.sv
module xpt_host_decode
    import xpt_cfg_pkg::*;
#(
    parameter int NPORT    = XPT_PORTS,
    parameter int AW       = XPT_ADDR_W,
    parameter int DRV_BASE = XPT_DRV_BASE,
    localparam int RW      = $clog2(NPORT)
) (
    input  logic [AW-1:0] addr,
    output bank_e         bank,
    output logic [RW-1:0] row
);
    int a_int;

    always_comb begin
        a_int = int'(addr);
        bank  = BANK_NONE;
        row   = '0;
        if (a_int < NPORT) begin
            bank = BANK_CONN;
            row  = RW'(a_int);
        end else if (a_int >= DRV_BASE && a_int < DRV_BASE + NPORT) begin
            bank = BANK_DRV;
            row  = RW'(a_int - DRV_BASE);
        end
    end
endmodule

// File: rtl/xpt_reg_rank.sv
module xpt_reg_rank #(
    parameter int NPORT = 34,
    parameter int CW    = 6,
    parameter logic [CW-1:0] RST_VAL = '0,
    localparam int RW   = $clog2(NPORT)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [RW-1:0]       wr_row,
    input  logic [CW-1:0]       wr_data,
    input  logic                xpar,
    input  logic                upd,
    output logic [NPORT*CW-1:0] stage_q,
    output logic [NPORT*CW-1:0] active_q
);
    for (genvar r = 0; r < NPORT; r++) begin : g_row
        logic hit;
        assign hit = wr_en && (wr_row == RW'(r));

        always_ff @(posedge clk) begin
            if (rst) begin
                stage_q[r*CW +: CW]  <= RST_VAL;
                active_q[r*CW +: CW] <= RST_VAL;
            end else begin
                if (hit) begin
                    stage_q[r*CW +: CW] <= wr_data;
                end
                if (hit && xpar) begin
                    active_q[r*CW +: CW] <= wr_data;
                end else if (upd) begin
                    // Copies the value staged before this edge.
                    active_q[r*CW +: CW] <= stage_q[r*CW +: CW];
                end
            end
        end
    end
endmodule

// File: rtl/xpt_lane_mux.sv
module xpt_lane_mux
    import xpt_cfg_pkg::*;
#(
    parameter int NPORT = XPT_PORTS,
    parameter int CW    = XPT_CODE_W
) (
    input  logic [NPORT-1:0]    lane_in,
    input  logic [NPORT*CW-1:0] sel_codes,
    output logic [NPORT-1:0]    lane_out
);
    localparam int SPAN = 2 ** CW;

    logic [SPAN-1:0] lane_pad;
    assign lane_pad = SPAN'(lane_in);

    for (genvar o = 0; o < NPORT; o++) begin : g_out
        logic [CW-1:0] code;
        logic          live;
        assign code        = sel_codes[o*CW +: CW];
        assign live        = code_connects(int'(code), NPORT);
        assign lane_out[o] = live ? lane_pad[code] : 1'b0;
    end
endmodule

// File: rtl/xpt_cfg_bank.sv
module xpt_cfg_bank
    import xpt_cfg_pkg::*;
#(
    parameter int NPORT    = XPT_PORTS,
    parameter int CW       = XPT_CODE_W,
    parameter int AW       = XPT_ADDR_W,
    parameter int DRV_BASE = XPT_DRV_BASE
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [AW-1:0]       hp_addr,
    input  logic [CW-1:0]       hp_wdata,
    input  logic                hp_cs,
    input  logic                hp_we,
    input  logic                hp_re,
    input  logic                hp_upd,
    input  logic                hp_xpar,
    input  logic [NPORT-1:0]    lane_in,
    output logic [NPORT-1:0]    lane_out,
    output logic [CW-1:0]       rd_data,
    output logic [NPORT*CW-1:0] drv_code
);
    localparam int RW = $clog2(NPORT);

    bank_e         bank;
    logic [RW-1:0] row;
    logic          wr_any;
    logic          rd_any;

    logic [NPORT*CW-1:0] conn_stage;
    logic [NPORT*CW-1:0] conn_active;
    logic [NPORT*CW-1:0] drv_stage;
    logic [NPORT*CW-1:0] drv_active;

    assign wr_any = hp_cs && hp_we;
    assign rd_any = hp_cs && hp_re;

    xpt_host_decode #(.NPORT(NPORT), .AW(AW), .DRV_BASE(DRV_BASE)) u_dec (
        .addr (hp_addr),
        .bank (bank),
        .row  (row)
    );

    xpt_reg_rank #(.NPORT(NPORT), .CW(CW), .RST_VAL({CW{1'b1}})) u_conn (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_any && bank == BANK_CONN),
        .wr_row   (row),
        .wr_data  (hp_wdata),
        .xpar     (hp_xpar),
        .upd      (hp_upd),
        .stage_q  (conn_stage),
        .active_q (conn_active)
    );

    xpt_reg_rank #(.NPORT(NPORT), .CW(CW), .RST_VAL('0)) u_drv (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_any && bank == BANK_DRV),
        .wr_row   (row),
        .wr_data  (hp_wdata),
        .xpar     (hp_xpar),
        .upd      (hp_upd),
        .stage_q  (drv_stage),
        .active_q (drv_active)
    );

    xpt_lane_mux #(.NPORT(NPORT), .CW(CW)) u_mux (
        .lane_in   (lane_in),
        .sel_codes (conn_active),
        .lane_out  (lane_out)
    );

    assign drv_code = drv_active;

    always_comb begin
        rd_data = '0;
        if (rd_any) begin
            unique case (bank)
                BANK_CONN: rd_data = conn_active[int'(row)*CW +: CW];
                BANK_DRV:  rd_data = drv_active[int'(row)*CW +: CW];
                default:   rd_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/xpt_cfg_bank_chk.sv
module xpt_cfg_bank_chk #(
    parameter int NPORT    = 34,
    parameter int CW       = 6,
    parameter int AW       = 7,
    parameter int DRV_BASE = 64
) (
    input logic                clk,
    input logic                rst,
    input logic [AW-1:0]       hp_addr,
    input logic                hp_cs,
    input logic                hp_we,
    input logic                hp_re,
    input logic                hp_upd,
    input logic                hp_xpar,
    input logic [NPORT-1:0]    lane_out,
    input logic [CW-1:0]       rd_data,
    input logic [NPORT*CW-1:0] conn_stage,
    input logic [NPORT*CW-1:0] conn_active,
    input logic [NPORT*CW-1:0] drv_stage,
    input logic [NPORT*CW-1:0] drv_active
);
    logic wr_any;
    logic addr_bad;
    assign wr_any   = hp_cs && hp_we;
    assign addr_bad = !(int'(hp_addr) < NPORT) &&
                      !(int'(hp_addr) >= DRV_BASE && int'(hp_addr) < DRV_BASE + NPORT);

    // R1: the cycle after reset everything is at its default
    a_r1_reset_default: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (&conn_active) && (drv_active == '0) && (lane_out == '0));

    // R3: an update without a write loads the previous staging contents
    a_r3_update_copies: assert property (@(posedge clk) disable iff (rst)
        ($past(hp_upd) && !$past(wr_any) && !$past(rst)) |->
            (conn_active == $past(conn_stage)) && (drv_active == $past(drv_stage)));

    // R2: without update, transparent write or reset the active rank holds
    a_r2_active_holds: assert property (@(posedge clk) disable iff (rst)
        (!$past(hp_upd) && !$past(wr_any && hp_xpar) && !$past(rst)) |->
            $stable(conn_active) && $stable(drv_active));

    // R5: read data is zero unless selected and read enabled
    a_r5_read_gated: assert property (@(posedge clk) disable iff (rst)
        !(hp_cs && hp_re) |-> (rd_data == '0));

    // R7: a write to an unmapped address leaves staging untouched
    a_r7_bad_addr_ignored: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_any && addr_bad) && !$past(rst)) |->
            $stable(conn_stage) && $stable(drv_stage));

    // R10: without chip select staging never changes
    a_r10_cs_required: assert property (@(posedge clk) disable iff (rst)
        (!$past(hp_cs) && !$past(rst)) |-> $stable(conn_stage) && $stable(drv_stage));
endmodule

bind xpt_cfg_bank xpt_cfg_bank_chk #(
    .NPORT(NPORT), .CW(CW), .AW(AW), .DRV_BASE(DRV_BASE)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .hp_addr     (hp_addr),
    .hp_cs       (hp_cs),
    .hp_we       (hp_we),
    .hp_re       (hp_re),
    .hp_upd      (hp_upd),
    .hp_xpar     (hp_xpar),
    .lane_out    (lane_out),
    .rd_data     (rd_data),
    .conn_stage  (conn_stage),
    .conn_active (conn_active),
    .drv_stage   (drv_stage),
    .drv_active  (drv_active)
);

// File: tb/xpt_cfg_bank_tb.sv
module xpt_cfg_bank_tb;
    localparam int NP = 34;
    localparam int CW = 6;

    logic              clk = 0;
    logic              rst = 1;
    logic [6:0]        hp_addr = '0;
    logic [CW-1:0]     hp_wdata = '0;
    logic              hp_cs = 0, hp_we = 0, hp_re = 0, hp_upd = 0, hp_xpar = 0;
    logic [NP-1:0]     lane_in = '0;
    logic [NP-1:0]     lane_out;
    logic [CW-1:0]     rd_data;
    logic [NP*CW-1:0]  drv_code;

    xpt_cfg_bank u_dut (
        .clk(clk), .rst(rst), .hp_addr(hp_addr), .hp_wdata(hp_wdata),
        .hp_cs(hp_cs), .hp_we(hp_we), .hp_re(hp_re), .hp_upd(hp_upd),
        .hp_xpar(hp_xpar), .lane_in(lane_in), .lane_out(lane_out),
        .rd_data(rd_data), .drv_code(drv_code)
    );

    always #10 clk = ~clk;   // 50 MHz

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // reference model from the requirements
    int sc[NP], ac[NP], si[NP], ai[NP];
    bit p_valid = 0;
    int p_a, p_d;
    bit p_cs, p_we, p_up, p_xp;

    // scoreboard queues
    string            tq[$];
    logic [NP-1:0]    lq[$];
    logic [CW-1:0]    rq[$];
    logic [NP*CW-1:0] dq[$];

    function automatic void model_reset();
        for (int r = 0; r < NP; r++) begin
            sc[r] = 63; ac[r] = 63; si[r] = 0; ai[r] = 0;
        end
    endfunction

    function automatic void model_apply();
        int oc[NP];
        int oi[NP];
        int bank;
        int row;
        if (!p_valid) return;
        oc = sc; oi = si;
        bank = 0; row = 0;
        if (p_cs && p_we) begin
            if (p_a < NP) begin bank = 1; row = p_a; end
            else if (p_a >= 64 && p_a < 64 + NP) begin bank = 2; row = p_a - 64; end
        end
        if (bank == 1) sc[row] = p_d;
        if (bank == 2) si[row] = p_d;
        if (p_up) begin
            for (int r = 0; r < NP; r++) begin ac[r] = oc[r]; ai[r] = oi[r]; end
        end
        if (p_xp && bank == 1) ac[row] = p_d;
        if (p_xp && bank == 2) ai[row] = p_d;
    endfunction

    task automatic step(input string tag, input int a, input int d,
                        input bit cs, input bit we, input bit re,
                        input bit up, input bit xp, input logic [NP-1:0] ln);
        logic [NP-1:0]    el;
        logic [CW-1:0]    er;
        logic [NP*CW-1:0] ed;
        @(posedge clk); #1;
        model_apply();
        hp_addr = 7'(a); hp_wdata = CW'(d); hp_cs = cs; hp_we = we;
        hp_re = re; hp_upd = up; hp_xpar = xp; lane_in = ln;
        p_valid = 1; p_a = a; p_d = d; p_cs = cs; p_we = we; p_up = up; p_xp = xp;
        for (int o = 0; o < NP; o++) begin
            el[o] = (ac[o] < NP) ? ln[ac[o]] : 1'b0;
            ed[o*CW +: CW] = CW'(ai[o]);
        end
        er = '0;
        if (cs && re) begin
            if (a < NP) er = CW'(ac[a]);
            else if (a >= 64 && a < 64 + NP) er = CW'(ai[a - 64]);
        end
        tq.push_back(tag); lq.push_back(el); rq.push_back(er); dq.push_back(ed);
    endtask

    // monitor
    always @(negedge clk) begin
        if (tq.size() > 0) begin
            string t;
            logic [NP-1:0] el;
            logic [CW-1:0] er;
            logic [NP*CW-1:0] ed;
            t = tq.pop_front(); el = lq.pop_front(); er = rq.pop_front(); ed = dq.pop_front();
            checks += 3;
            if (lane_out !== el) begin
                failures++;
                $display("FAIL %s lane_out actual=%h expected=%h", t, lane_out, el);
            end
            if (rd_data !== er) begin
                failures++;
                $display("FAIL %s rd_data actual=%0d expected=%0d", t, rd_data, er);
            end
            if (drv_code !== ed) begin
                failures++;
                $display("FAIL %s drv_code actual=%h expected=%h", t, drv_code, ed);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    localparam logic [NP-1:0] ONES = '1;
    localparam logic [NP-1:0] PAT1 = 34'h2_AAAA_5555;
    localparam logic [NP-1:0] PAT2 = 34'h1_0F0F_F0F0;

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R1: defaults after reset
        step("R1", 0, 0, 1, 0, 1, 0, 0, ONES);
        step("R1", 64, 0, 1, 0, 1, 0, 0, ONES);
        step("R1", 33, 0, 1, 0, 1, 0, 0, PAT1);
        // R2: staged writes do not reach the switch
        step("R2", 3, 7, 1, 1, 0, 0, 0, ONES);
        step("R2", 3, 0, 1, 0, 1, 0, 0, ONES);
        step("R2", 0, 33, 1, 1, 0, 0, 0, ONES);
        step("R2", 33, 0, 1, 1, 0, 0, 0, ONES);
        step("R2", 10, 40, 1, 1, 0, 0, 0, ONES);
        step("R6", 64, 21, 1, 1, 0, 0, 0, ONES);
        step("R6", 97, 5, 1, 1, 0, 0, 0, ONES);
        step("R2", 0, 0, 1, 0, 1, 0, 0, PAT1);
        // R3: global update
        step("R3", 0, 0, 0, 0, 0, 1, 0, PAT1);
        // R4: routing under several patterns
        step("R4", 0, 0, 1, 0, 1, 0, 0, PAT1);
        step("R4", 3, 0, 1, 0, 1, 0, 0, PAT2);
        step("R4", 10, 0, 1, 0, 1, 0, 0, ONES);
        step("R4", 33, 0, 1, 0, 1, 0, 0, 34'h0_0000_0001);
        step("R4", 0, 0, 0, 0, 0, 0, 0, 34'h2_0000_0008);
        // R5/R6: readback of both banks; gating
        step("R6", 97, 0, 1, 0, 1, 0, 0, PAT2);
        step("R6", 64, 0, 1, 0, 1, 0, 0, PAT2);
        step("R5", 65, 0, 1, 0, 1, 0, 0, PAT2);
        step("R5", 3, 0, 0, 0, 1, 0, 0, PAT2);
        step("R5", 3, 0, 1, 0, 0, 0, 0, PAT2);
        step("R5", 50, 0, 1, 0, 1, 0, 0, PAT2);
        // R7: unmapped addresses
        step("R7", 34, 1, 1, 1, 0, 0, 0, PAT1);
        step("R7", 63, 1, 1, 1, 0, 0, 1, PAT1);
        step("R7", 98, 2, 1, 1, 0, 0, 0, PAT1);
        step("R7", 127, 2, 1, 1, 0, 0, 1, PAT1);
        step("R7", 0, 0, 0, 0, 0, 1, 0, PAT1);
        step("R7", 34, 0, 1, 0, 1, 0, 0, PAT1);
        step("R7", 98, 0, 1, 0, 1, 0, 0, PAT1);
        // R10: write without chip select
        step("R10", 3, 1, 0, 1, 0, 0, 1, PAT1);
        step("R10", 3, 1, 0, 1, 0, 1, 0, PAT1);
        step("R10", 3, 0, 1, 0, 1, 0, 0, PAT1);
        // R8: transparent write applies at once
        step("R8", 5, 2, 1, 1, 0, 0, 1, PAT2);
        step("R8", 5, 0, 1, 0, 1, 0, 0, PAT2);
        step("R8", 70, 9, 1, 1, 0, 0, 1, PAT2);
        step("R8", 70, 0, 1, 0, 1, 0, 0, PAT2);
        // R9: update colliding with a write to the same row
        step("R9", 6, 4, 1, 1, 0, 0, 0, PAT1);
        step("R9", 6, 9, 1, 1, 0, 1, 0, PAT1);
        step("R9", 6, 0, 1, 0, 1, 0, 0, PAT1);
        step("R9", 0, 0, 0, 0, 0, 1, 0, PAT1);
        step("R9", 6, 0, 1, 0, 1, 0, 0, PAT2);
        // R1: reset again after a busy map
        @(posedge clk); #1;
        hp_cs = 0; hp_we = 0; hp_re = 0; hp_upd = 0; hp_xpar = 0;
        rst = 1;
        @(negedge clk);
        @(posedge clk); #1;
        rst = 0;
        model_reset();
        p_valid = 0;
        step("R1", 6, 0, 1, 0, 1, 0, 0, ONES);
        step("R1", 97, 0, 1, 0, 1, 0, 0, ONES);
        step("R1", 0, 0, 0, 0, 0, 0, 0, ONES);
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule